// File: doc/BRIEF.md
# Index-Gated Block Loader with Additive Checksum

This block sits behind a synchronous serial receiver and pulls one block of data off the medium into memory. It waits for the rotational index signal to pulse (go active, then inactive), clears the receiver, and expects the very next received byte to be the sync code. A four-byte header follows: the destination address and then the byte count, each little-endian. Every payload byte is written to memory through a single-cycle write port at rising addresses. A 16-bit sum of the payload is kept on the fly.

After the payload, a 16-bit checksum arrives low byte first. When it equals the running sum, the block holds `done` high and presents the load address. A wrong sync byte or a checksum mismatch raises a one-cycle `retry` pulse. The engine then returns to waiting for a fresh index pulse. The front end takes its sync pattern from a constant output of this block.

Top module: `frame_loader`

## Requirements
- R1: After reset, `done`, `retry`, `rxReset` and `memWe` are all 0, and `syncPattern` always carries the sync code 0x81.
- R2: Received bytes are ignored until `indexIn` has been sampled high and later sampled low. `rxReset` is high for exactly the cycle after the clock edge that samples `indexIn` low.
- R3: If the first byte accepted after `rxReset` is not 0x81, `retry` is high for one cycle, and nothing is written to memory.
- R4: After the sync byte, the next four accepted bytes are taken in this order: address low, address high, count low, count high.
- R5: Each payload byte asserts `memWe` in the same cycle it is presented with `rxValid`. `memData` equals the byte, and `memAddr` starts at the header address and rises by one per byte, wrapping modulo 65536.
- R6: A byte count of 0 loads 65536 payload bytes.
- R7: Two checksum bytes follow the payload, low byte first. When they equal the modulo-65536 sum of the payload bytes (each taken as unsigned), `done` rises on the edge that accepts the high checksum byte. `done` then stays high and `loadAddr` shows the header address. Header, sync and checksum bytes never write memory.
- R8: On a checksum mismatch, `retry` pulses for one cycle and `done` stays 0. The whole sequence restarts: bytes are ignored again until a new index pulse. A later correct frame completes normally.
- R9: Cycles with `rxValid` low change nothing. Gaps between bytes anywhere in a frame do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| indexIn | input | 1 | Index pulse from the drive, active high |
| rxValid | input | 1 | Receiver presents a byte this cycle |
| rxData | input | 8 | Received byte |
| rxReset | output | 1 | One-cycle clear for the receiver |
| syncPattern | output | 8 | Sync code for the front end to hunt for |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory write address |
| memData | output | 8 | Memory write data |
| done | output | 1 | Block loaded and checksum matched |
| retry | output | 1 | One-cycle pulse on a failed frame |
| loadAddr | output | 16 | Start address from the header |

## Verification
Two things can happen in the same cycle: the write of the last payload byte and the count running out. In that cycle the engine must also switch to collecting the checksum. The bench provokes this by holding `rxValid` high across the end of the payload, so the low checksum byte follows the last data byte on the very next cycle. It judges the result by counting every `memWe` cycle against the requested length, and by requiring that the checksum byte is never written to memory. Frames with gaps, a zero count and an address that wraps run the same boundary from other directions.

// File: rtl/frame_loader_pkg.sv
`timescale 1ns/1ps
package frame_loader_pkg;
  localparam int DATA_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = DATA_W * LANES;

  typedef enum logic [3:0] {
    S_IDXHI, S_IDXLO, S_RXRST, S_SYNC,
    S_ADRLO, S_ADRHI, S_CNTLO, S_CNTHI,
    S_DATA,  S_SUMLO, S_SUMHI, S_DONE
  } ldState_e;

  typedef struct packed {
    logic [LANES-1:0] ldAdr;
    logic [LANES-1:0] ldCnt;
    logic             takeData;
    logic             ldSumLo;
    logic             clrSum;
  } dpStrobe_t;
endpackage

// File: rtl/frame_loader_ctrl.sv
`timescale 1ns/1ps
module frame_loader_ctrl
  import frame_loader_pkg::*;
#(
  parameter logic [DATA_W-1:0] SYNC_CODE = 8'h81
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              indexIn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              cntLast,
  input  logic              sumMatch,
  output dpStrobe_t         strb,
  output logic              rxReset,
  output logic              done,
  output logic              retry
);
  ldState_e state, nextState;
  logic     failNow;
  logic     retryQ;

  always_comb begin
    strb      = '0;
    nextState = state;
    failNow   = 1'b0;
    case (state)
      S_IDXHI: if (indexIn)  nextState = S_IDXLO;
      S_IDXLO: if (!indexIn) nextState = S_RXRST;
      S_RXRST: begin
        strb.clrSum = 1'b1;
        nextState   = S_SYNC;
      end
      S_SYNC: if (rxValid) begin
        if (rxData == SYNC_CODE) nextState = S_ADRLO;
        else begin
          failNow   = 1'b1;
          nextState = S_IDXHI;
        end
      end
      S_ADRLO: if (rxValid) begin
        strb.ldAdr[0] = 1'b1;
        nextState     = S_ADRHI;
      end
      S_ADRHI: if (rxValid) begin
        strb.ldAdr[1] = 1'b1;
        nextState     = S_CNTLO;
      end
      S_CNTLO: if (rxValid) begin
        strb.ldCnt[0] = 1'b1;
        nextState     = S_CNTHI;
      end
      S_CNTHI: if (rxValid) begin
        strb.ldCnt[1] = 1'b1;
        nextState     = S_DATA;
      end
      S_DATA: if (rxValid) begin
        strb.takeData = 1'b1;
        if (cntLast) nextState = S_SUMLO;
      end
      S_SUMLO: if (rxValid) begin
        strb.ldSumLo = 1'b1;
        nextState    = S_SUMHI;
      end
      S_SUMHI: if (rxValid) begin
        if (sumMatch) nextState = S_DONE;
        else begin
          failNow   = 1'b1;
          nextState = S_IDXHI;
        end
      end
      S_DONE:  nextState = S_DONE;
      default: nextState = S_IDXHI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDXHI;
      retryQ <= 1'b0;
    end else begin
      state  <= nextState;
      retryQ <= failNow;
    end
  end

  assign rxReset = (state == S_RXRST);
  assign done    = (state == S_DONE);
  assign retry   = retryQ;

  // R1
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, retry, rxReset}));

  // R2
  rxreset_after_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |-> ($past(state) == S_IDXLO && !$past(indexIn)));

  // R8
  retry_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    retry |-> (state == S_IDXHI));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);
endmodule

// File: rtl/frame_loader_dp.sv
`timescale 1ns/1ps
module frame_loader_dp
  import frame_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] rxData,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [WORD_W-1:0] loadAddr,
  output logic              cntLast,
  output logic              sumMatch
);
  logic [WORD_W-1:0] startAddr, ptr, cnt, acc;
  logic [DATA_W-1:0] sumLo;
  logic [WORD_W-1:0] adrMerge, ptrMerge, cntMerge;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign adrMerge[g*DATA_W +: DATA_W] = strb.ldAdr[g] ? rxData : startAddr[g*DATA_W +: DATA_W];
    assign ptrMerge[g*DATA_W +: DATA_W] = strb.ldAdr[g] ? rxData : ptr[g*DATA_W +: DATA_W];
    assign cntMerge[g*DATA_W +: DATA_W] = strb.ldCnt[g] ? rxData : cnt[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      ptr       <= '0;
      cnt       <= '0;
      acc       <= '0;
      sumLo     <= '0;
    end else begin
      startAddr <= adrMerge;
      if (strb.takeData) begin
        ptr <= ptr + 1'b1;
        cnt <= cnt - 1'b1;
        acc <= acc + WORD_W'(rxData);
      end else begin
        ptr <= ptrMerge;
        cnt <= cntMerge;
        if (strb.clrSum) acc <= '0;
      end
      if (strb.ldSumLo) sumLo <= rxData;
    end
  end

  assign memWe    = strb.takeData;
  assign memAddr  = ptr;
  assign memData  = rxData;
  assign loadAddr = startAddr;
  assign cntLast  = (cnt == WORD_W'(1));
  assign sumMatch = ({rxData, sumLo} == acc);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |=> (ptr == $past(ptr) + 1'b1));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |=> (cnt == $past(cnt) - 1'b1));

  // R7
  acc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |=> (acc == $past(acc) + WORD_W'($past(rxData))));

  // R4
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |=> $stable(startAddr));
endmodule

// File: rtl/frame_loader.sv
`timescale 1ns/1ps
module frame_loader
  import frame_loader_pkg::*;
#(
  parameter logic [7:0] SYNC_CODE = 8'h81
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        indexIn,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  output logic        rxReset,
  output logic [7:0]  syncPattern,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memData,
  output logic        done,
  output logic        retry,
  output logic [15:0] loadAddr
);
  dpStrobe_t strb;
  logic      cntLast, sumMatch;

  frame_loader_ctrl #(.SYNC_CODE(SYNC_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .indexIn(indexIn), .rxValid(rxValid),
    .rxData(rxData), .cntLast(cntLast), .sumMatch(sumMatch),
    .strb(strb), .rxReset(rxReset), .done(done), .retry(retry)
  );

  frame_loader_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .loadAddr(loadAddr), .cntLast(cntLast), .sumMatch(sumMatch)
  );

  assign syncPattern = SYNC_CODE;
endmodule

// File: tb/frame_loader_test.sv
`timescale 1ns/1ps
module frame_loader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        indexIn = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReset, memWe, done, retry;
  logic [7:0]  syncPattern, memData;
  logic [15:0] memAddr, loadAddr;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int wrBad = 0;
  logic [15:0] expAddr = '0;

  always #10 clk = ~clk;

  frame_loader uut (
    .clk(clk), .rstN(rstN), .indexIn(indexIn), .rxValid(rxValid), .rxData(rxData),
    .rxReset(rxReset), .syncPattern(syncPattern), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .done(done), .retry(retry), .loadAddr(loadAddr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxValid = 1'b0; indexIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    #5;
    if (memWe) begin
      wrCount++;
      if (memAddr !== expAddr || memData !== b) wrBad++;
      expAddr = expAddr + 16'd1;
    end
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxValid = 1'b0;
      #5;
      if (memWe) begin wrCount++; wrBad++; end
    end
  endtask

  task automatic pulseIndex();
    @(negedge clk);
    rxValid = 1'b0; indexIn = 1'b1;
    @(negedge clk);
    indexIn = 1'b0;
    @(posedge clk);
    #5;
    chk(rxReset === 1'b1, "R2 rxReset after index fall", rxReset, 1);
    @(posedge clk);
  endtask

  // sends a frame after an index pulse; returns after the last byte's edge
  task automatic sendFrame(input logic [15:0] addr, input logic [15:0] len,
                           input int seed, input bit corrupt, input bit gaps);
    logic [15:0] sum;
    int n;
    pulseIndex();
    sendByte(8'h81);
    if (gaps) gap(1);
    sendByte(addr[7:0]);
    sendByte(addr[15:8]);
    if (gaps) gap(2);
    sendByte(len[7:0]);
    sendByte(len[15:8]);
    expAddr = addr; wrCount = 0; wrBad = 0; sum = '0;
    n = (len == 16'd0) ? 65536 : int'(len);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + seed) & 255);
      sendByte(b);
      sum = sum + 16'(b);
      if (gaps && (i % 3 == 0)) gap(2);
    end
    if (corrupt) sum = sum ^ 16'h0100;
    sendByte(sum[7:0]);
    if (gaps) gap(3);
    sendByte(sum[15:8]);
    gap(1);
  endtask

  task automatic testReset();
    doReset();
    #5;
    chk(done === 1'b0, "R1 done", done, 0);
    chk(retry === 1'b0, "R1 retry", retry, 0);
    chk(rxReset === 1'b0 && memWe === 1'b0, "R1 rxReset/memWe", {rxReset, memWe}, 0);
    chk(syncPattern === 8'h81, "R1 syncPattern", syncPattern, 8'h81);
  endtask

  task automatic testNoIndex();
    doReset();
    wrCount = 0;
    sendByte(8'h81); sendByte(8'h00); sendByte(8'h10); sendByte(8'h02); sendByte(8'h00);
    sendByte(8'hAA); sendByte(8'hBB);
    gap(1);
    chk(wrCount == 0 && done === 1'b0, "R2 bytes ignored without index", wrCount, 0);
    @(negedge clk); indexIn = 1'b1;
    sendByte(8'h81); sendByte(8'h00); sendByte(8'h10); sendByte(8'h01); sendByte(8'h00); sendByte(8'h11);
    gap(1);
    chk(wrCount == 0 && rxReset === 1'b0, "R2 ignored while index high", wrCount, 0);
    indexIn = 1'b0;
  endtask

  task automatic testBadSync();
    doReset();
    pulseIndex();
    wrCount = 0;
    sendByte(8'h55);
    gap(1);
    chk(retry === 1'b1, "R3 retry on bad sync", retry, 1);
    gap(1);
    chk(retry === 1'b0, "R3 retry one cycle", retry, 0);
    sendByte(8'h81); sendByte(8'h00); sendByte(8'h20); sendByte(8'h02); sendByte(8'h00);
    sendByte(8'h01); sendByte(8'h02); sendByte(8'h03); sendByte(8'h00);
    gap(1);
    chk(wrCount == 0 && done === 1'b0, "R8 waits for new index after fail", wrCount, 0);
  endtask

  task automatic testGood();
    doReset();
    sendFrame(16'h4000, 16'd5, 3, 1'b0, 1'b0);
    chk(done === 1'b1, "R7 done on match", done, 1);
    chk(wrCount == 5, "R5 write count back-to-back", wrCount, 5);
    chk(wrBad == 0, "R5 addresses/data", wrBad, 0);
    chk(loadAddr === 16'h4000, "R4 loadAddr", loadAddr, 16'h4000);
    gap(4);
    chk(done === 1'b1 && wrCount == 5, "R7 done held", done, 1);
  endtask

  task automatic testGaps();
    doReset();
    sendFrame(16'hFFFE, 16'd6, 91, 1'b0, 1'b1);
    chk(done === 1'b1, "R9 done with gaps", done, 1);
    chk(wrCount == 6 && wrBad == 0, "R9 writes with gaps and wrap", wrCount, 6);
    chk(loadAddr === 16'hFFFE, "R4 loadAddr high byte", loadAddr, 16'hFFFE);
  endtask

  task automatic testBadSum();
    doReset();
    sendFrame(16'h1200, 16'd300, 200, 1'b1, 1'b0);
    chk(retry === 1'b1 && done === 1'b0, "R8 retry on mismatch", {retry, done}, 2);
    gap(1);
    chk(retry === 1'b0, "R8 retry pulse width", retry, 0);
    sendFrame(16'h1200, 16'd300, 200, 1'b0, 1'b0);
    chk(done === 1'b1, "R7 carry into high byte", done, 1);
    chk(wrCount == 300 && wrBad == 0, "R8 retry frame writes", wrCount, 300);
  endtask

  task automatic testZeroLen();
    doReset();
    sendFrame(16'h8000, 16'd0, 5, 1'b0, 1'b0);
    chk(wrCount == 65536, "R6 zero count is 65536", wrCount, 65536);
    chk(wrBad == 0 && done === 1'b1, "R6 full block done", done, 1);
    chk(loadAddr === 16'h8000, "R6 loadAddr", loadAddr, 16'h8000);
  endtask

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testNoIndex();
    testBadSync();
    testGood();
    testGaps();
    testBadSum();
    testZeroLen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule